// File: doc/BRIEF.md
# Polled Factorial Engine Register Block

This block is a small register file on a 32-bit memory-mapped register bus. It holds a fixed identification word and a scratch register that keeps the bitwise inverse of each value written to it. Its main part is a factorial engine: software writes an operand, the engine multiplies the partial product by one factor per clock, and software polls a busy bit before it reads the result. The block also collects interrupt causes in one status word and drives a single level-sensitive interrupt line.

There are two interrupt causes. The first is completion of a factorial, which raises a cause bit only when software has set an enable. The second is a one-cycle completion pulse from an external DMA engine. Software can also set or clear any cause bit by hand, using two write-only registers: one sets the bits written as ones, the other clears them. Reads have no side effects. Any access whose size field is not 4 bytes is dropped.

Top module: `fact_accel_regs`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED. Writes to 0x00 change nothing.
- R2: A 4-byte write to 0x04 stores the bitwise complement of the write data. A read of 0x04 returns the stored word.
- R3: A 4-byte write of n to 0x08 while idle starts the engine. Status bit 0 at 0x20 is set from the next cycle and stays set for exactly n+1 clock edges after the write edge. A read of 0x08 while busy returns the partial product, which starts at 1 and takes one more factor per clock, from n downward.
- R4: When the engine finishes, status bit 0 clears and 0x08 returns n! modulo 2^32. An operand of 0 or 1 gives 1.
- R5: A write to 0x08 while status bit 0 is set is ignored. The running computation goes on and gives the result of the first operand.
- R6: Status bit 7 at 0x20 is a read/write interrupt enable. Bit 0 of 0x20 cannot be written. A completion while bit 7 is set sets bit 0 of the interrupt status at 0x24. A completion while bit 7 is clear leaves the interrupt status unchanged.
- R7: A write to 0x60 ORs the data into the interrupt status. A write to 0x64 clears the bits written as ones. A read of 0x24 returns the interrupt status.
- R8: `irq_o` is high exactly when the interrupt status is nonzero.
- R9: A one-cycle pulse on `dma_done_i` sets bit 8 (0x100) of the interrupt status. A cause set by hardware wins over a clear written to 0x64 in the same cycle.
- R10: An access with `bus_size` other than 4 has no effect when it is a write, and returns 0xFFFFFFFF when it is a read. A read of any offset without a readable register (including 0x60, 0x64 and everything from 0x80 up) returns 0xFFFFFFFF.
- R11: Reset sets the scratch register, result, status and interrupt status to zero and drives `irq_o` low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | SIZE_W | Access size in bytes; only 4 is accepted |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset presented, combinational |
| dma_done_i | input | 1 | One-cycle DMA completion pulse |
| irq_o | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
The bench builds the block with `ADDR_W` set to 12. This keeps the whole register window small enough that a probe near its top, at 0xFFC, and probes in the 0x80 region both go through the unmapped-read path. The identification word and the 4-byte size code stay at their defaults, so the expected values are the fixed constants given in the requirements. The operands 0, 1, 4, 5, 6, 3 and 13 exercise these cases: the empty product, the shortest busy window, partial products read mid-run, a rejected second operand, and a result that wraps past 32 bits.

// File: rtl/fact_accel_pkg.sv
package fact_accel_pkg;

  localparam int unsigned WORD_W = 32;

  // register offsets (bytes)
  localparam int unsigned OFS_IDENT  = 'h00;
  localparam int unsigned OFS_SCRAT  = 'h04;
  localparam int unsigned OFS_FACT   = 'h08;
  localparam int unsigned OFS_STAT   = 'h20;
  localparam int unsigned OFS_ISR    = 'h24;
  localparam int unsigned OFS_RAISE  = 'h60;
  localparam int unsigned OFS_LOWER  = 'h64;

  // bit positions software decodes
  localparam int unsigned STS_BUSY_B = 0;
  localparam int unsigned STS_IEN_B  = 7;
  localparam int unsigned IRQ_FACT_B = 0;
  localparam int unsigned IRQ_DMA_B  = 8;

  localparam int unsigned ACCESS_BYTES = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_SCRAT,
    SEL_FACT,
    SEL_STAT,
    SEL_ISR,
    SEL_RAISE,
    SEL_LOWER
  } reg_sel_e;

endpackage

// File: rtl/fact_rst_sync.sv
module fact_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fact_addr_decode.sv
module fact_addr_decode
  import fact_accel_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output reg_sel_e          sel_o,
  output logic              size_ok_o
);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_SCRAT = ADDR_W'(OFS_SCRAT);
  localparam logic [ADDR_W-1:0] A_FACT  = ADDR_W'(OFS_FACT);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFS_ISR);
  localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(OFS_LOWER);

  always_comb begin
    case (addr_i)
      A_IDENT: sel_o = SEL_IDENT;
      A_SCRAT: sel_o = SEL_SCRAT;
      A_FACT:  sel_o = SEL_FACT;
      A_STAT:  sel_o = SEL_STAT;
      A_ISR:   sel_o = SEL_ISR;
      A_RAISE: sel_o = SEL_RAISE;
      A_LOWER: sel_o = SEL_LOWER;
      default: sel_o = SEL_NONE;
    endcase
  end

  assign size_ok_o = (size_i == SIZE_W'(ACCESS_BYTES));
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  logic [W-1:0] prod_q, prod_d;
  logic [W-1:0] cnt_q,  cnt_d;
  logic         busy_q, busy_d;
  logic         eng_en;
  logic         last;

  assign last   = busy_q && (cnt_q == '0);
  assign eng_en = busy_q || start_i;

  always_comb begin
    prod_d = prod_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        prod_d = prod_q * cnt_q;
        cnt_d  = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      prod_d = W'(1);
      cnt_d  = operand_i;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (eng_en) begin
      prod_q <= prod_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = last;
  assign prod_o = prod_q;
endmodule

// File: rtl/fact_irq_status.sv
module fact_irq_status #(
  parameter int unsigned W      = 32,
  parameter int unsigned FACT_B = 0,
  parameter int unsigned DMA_B  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raise_we_i,
  input  logic         lower_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         fact_done_i,
  input  logic         fact_ien_i,
  input  logic         dma_done_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] hw_set, sw_set, sw_clr;
  logic         stat_en;

  always_comb begin
    hw_set         = '0;
    hw_set[FACT_B] = fact_done_i && fact_ien_i;
    hw_set[DMA_B]  = dma_done_i;
    sw_set         = raise_we_i ? wdata_i : '0;
    sw_clr         = lower_we_i ? wdata_i : '0;
    stat_en        = raise_we_i || lower_we_i || (hw_set != '0);
    // hardware causes are applied after the clear so none is lost
    stat_d         = (stat_q & ~sw_clr) | sw_set | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/fact_accel_regs.sv
module fact_accel_regs
  import fact_accel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SIZE_W  = 4,
  parameter logic [31:0] ID_WORD = 32'h010000ED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dma_done_i,
  output logic              irq_o
);
  localparam int unsigned W = WORD_W;

  logic         rst_sync_n;
  reg_sel_e     sel;
  logic         size_ok;
  logic         wr_ok;
  logic         fact_start, fact_busy, fact_done;
  logic [W-1:0] fact_prod;
  logic [W-1:0] irq_stat;
  logic [W-1:0] scratch_q, scratch_d;
  logic         scr_en;
  logic         ien_q, ien_d, ien_en;
  logic [W-1:0] stat_word;

  fact_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  fact_addr_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dec (
    .addr_i    (bus_addr),
    .size_i    (bus_size),
    .sel_o     (sel),
    .size_ok_o (size_ok)
  );

  assign wr_ok      = bus_wr && size_ok;
  assign fact_start = wr_ok && (sel == SEL_FACT);

  fact_engine #(.W(W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (fact_start),
    .operand_i (bus_wdata),
    .busy_o    (fact_busy),
    .done_o    (fact_done),
    .prod_o    (fact_prod)
  );

  fact_irq_status #(.W(W), .FACT_B(IRQ_FACT_B), .DMA_B(IRQ_DMA_B)) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .raise_we_i  (wr_ok && (sel == SEL_RAISE)),
    .lower_we_i  (wr_ok && (sel == SEL_LOWER)),
    .wdata_i     (bus_wdata),
    .fact_done_i (fact_done),
    .fact_ien_i  (ien_q),
    .dma_done_i  (dma_done_i),
    .stat_o      (irq_stat),
    .irq_o       (irq_o)
  );

  // next state of the locally held registers
  always_comb begin
    scr_en    = wr_ok && (sel == SEL_SCRAT);
    scratch_d = ~bus_wdata;
    ien_en    = wr_ok && (sel == SEL_STAT);
    ien_d     = bus_wdata[STS_IEN_B];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  scratch_q <= '0;
    else if (scr_en)  scratch_q <= scratch_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ien_q <= 1'b0;
    else if (ien_en)  ien_q <= ien_d;
  end

  always_comb begin
    stat_word             = '0;
    stat_word[STS_BUSY_B] = fact_busy;
    stat_word[STS_IEN_B]  = ien_q;
  end

  always_comb begin
    bus_rdata = '1;
    if (size_ok) begin
      case (sel)
        SEL_IDENT: bus_rdata = ID_WORD;
        SEL_SCRAT: bus_rdata = scratch_q;
        SEL_FACT:  bus_rdata = fact_prod;
        SEL_STAT:  bus_rdata = stat_word;
        SEL_ISR:   bus_rdata = irq_stat;
        default:   bus_rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/fact_accel_chk.sv
module fact_accel_chk #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SIZE_W  = 4,
  parameter logic [31:0] ID_WORD = 32'h010000ED
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              dma_done_i,
  input logic              irq_o,
  input logic              fact_start,
  input logic              fact_busy,
  input logic              fact_done,
  input logic [31:0]       irq_stat,
  input logic [31:0]       scratch_q,
  input logic              ien_q
);
  // R1
  id_const_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == '0 && bus_size == SIZE_W'(4)) |-> bus_rdata == ID_WORD);

  // R2
  scratch_inv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(4) && bus_size == SIZE_W'(4))
      |=> scratch_q == ~$past(bus_wdata));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fact_start && !fact_busy) |=> fact_busy);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fact_done |=> !fact_busy);

  // R6
  fact_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fact_done && ien_q) |=> irq_stat[0]);

  // R9
  dma_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_done_i |=> irq_stat[8]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past((bus_wr && bus_addr == ADDR_W'('h60) && bus_size == SIZE_W'(4))
                           || dma_done_i || (fact_done && ien_q)));

  // R10
  size_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_size != SIZE_W'(4)) |=> ($stable(scratch_q) && $stable(ien_q)));
endmodule

bind fact_accel_regs fact_accel_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ID_WORD(ID_WORD)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .dma_done_i (dma_done_i),
  .irq_o      (irq_o),
  .fact_start (fact_start),
  .fact_busy  (fact_busy),
  .fact_done  (fact_done),
  .irq_stat   (irq_stat),
  .scratch_q  (scratch_q),
  .ien_q      (ien_q)
);

// File: tb/sim_fact_accel_regs.sv
module sim_fact_accel_regs;
  localparam int unsigned AW = 12;
  localparam int unsigned SW = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [SW-1:0] bus_size;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          dma_done_i;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  fact_accel_regs #(.ADDR_W(AW), .SIZE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done_i(dma_done_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [SW-1:0] sz;
    logic [31:0]   d;
    logic [31:0]   exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    // R1 identification word, write ignored
    '{1'b0, 12'h000, 4'd4, 32'h0,         32'h010000ED, 4'd1},
    '{1'b1, 12'h000, 4'd4, 32'h0,         32'h0,        4'd1},
    '{1'b0, 12'h000, 4'd4, 32'h0,         32'h010000ED, 4'd1},
    // R2 inverting scratch
    '{1'b1, 12'h004, 4'd4, 32'h12345678,  32'h0,        4'd2},
    '{1'b0, 12'h004, 4'd4, 32'h0,         32'hEDCBA987, 4'd2},
    '{1'b1, 12'h004, 4'd4, 32'h0,         32'h0,        4'd2},
    '{1'b0, 12'h004, 4'd4, 32'h0,         32'hFFFFFFFF, 4'd2},
    '{1'b1, 12'h004, 4'd4, 32'h5555_0000, 32'h0,        4'd2},
    // R10 wrong sizes and unmapped offsets
    '{1'b1, 12'h004, 4'd2, 32'h0000_1234, 32'h0,        4'd10},
    '{1'b0, 12'h004, 4'd4, 32'h0,         32'hAAAAFFFF, 4'd10},
    '{1'b0, 12'h004, 4'd2, 32'h0,         32'hFFFFFFFF, 4'd10},
    '{1'b0, 12'h010, 4'd4, 32'h0,         32'hFFFFFFFF, 4'd10},
    '{1'b0, 12'h098, 4'd4, 32'h0,         32'hFFFFFFFF, 4'd10},
    '{1'b0, 12'hFFC, 4'd4, 32'h0,         32'hFFFFFFFF, 4'd10},
    // R7 raise / lower / read
    '{1'b1, 12'h060, 4'd4, 32'h00000011,  32'h0,        4'd7},
    '{1'b0, 12'h024, 4'd4, 32'h0,         32'h00000011, 4'd7},
    '{1'b1, 12'h064, 4'd4, 32'h00000001,  32'h0,        4'd7},
    '{1'b0, 12'h024, 4'd4, 32'h0,         32'h00000010, 4'd7},
    '{1'b1, 12'h064, 4'd4, 32'h00000010,  32'h0,        4'd7},
    '{1'b0, 12'h024, 4'd4, 32'h0,         32'h00000000, 4'd7},
    // R6 enable bit read/write, busy bit not writable
    '{1'b1, 12'h020, 4'd4, 32'h00000080,  32'h0,        4'd6},
    '{1'b0, 12'h020, 4'd4, 32'h0,         32'h00000080, 4'd6},
    '{1'b1, 12'h020, 4'd4, 32'hFFFFFF7F,  32'h0,        4'd6},
    '{1'b0, 12'h020, 4'd4, 32'h0,         32'h00000000, 4'd6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [SW-1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [SW-1:0] sz, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] fact_ref(input int n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= n; k++) r = r * 32'(k);
    return r;
  endfunction

  // counts reads that show the busy bit, from the edge after the write
  task automatic poll(output int polls);
    logic [31:0] s;
    polls = 0;
    for (int i = 0; i < 200; i++) begin
      rd(12'h020, 4'd4, s);
      if (s[0] == 1'b0) break;
      polls++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int p;
    rst_n = 1'b0; bus_addr = '0; bus_size = 4'd4; bus_wr = 1'b0;
    bus_wdata = '0; dma_done_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd(12'h004, 4'd4, v); chk("R11 scratch", v, 32'h0);
    rd(12'h008, 4'd4, v); chk("R11 result", v, 32'h0);
    rd(12'h020, 4'd4, v); chk("R11 status", v, 32'h0);
    rd(12'h024, 4'd4, v); chk("R11 irq status", v, 32'h0);
    chk("R11 irq_o", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d, VEC[i].sz);
      else begin
        rd(VEC[i].a, VEC[i].sz, v);
        chk($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].exp);
      end
    end

    // R3 partial products for n=4: 1, 4, 12, 24
    wr(12'h008, 32'd4, 4'd4);
    rd(12'h008, 4'd4, v); chk("R3 partial 0", v, 32'd1);
    rd(12'h008, 4'd4, v); chk("R3 partial 1", v, 32'd4);
    rd(12'h008, 4'd4, v); chk("R3 partial 2", v, 32'd12);
    rd(12'h008, 4'd4, v); chk("R3 partial 3", v, 32'd24);
    poll(p);
    rd(12'h008, 4'd4, v); chk("R4 result 4", v, 32'd24);

    // R3 busy window and R4 results, including 0 and a wrapping case
    foreach (VEC[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 13;
      wr(12'h008, 32'(n), 4'd4);
      poll(p);
      chk($sformatf("R3 busy polls n=%0d", n), 32'(p), 32'(n + 1));
      rd(12'h008, 4'd4, v);
      chk($sformatf("R4 result n=%0d", n), v, fact_ref(n));
    end
    rd(12'h024, 4'd4, v); chk("R6 no cause while disabled", v, 32'h0);

    // R5 second operand while busy is ignored
    wr(12'h008, 32'd6, 4'd4);
    wr(12'h008, 32'd2, 4'd4);
    poll(p);
    rd(12'h008, 4'd4, v); chk("R5 result kept", v, 32'd720);

    // R6 enabled completion raises bit 0
    wr(12'h020, 32'h80, 4'd4);
    wr(12'h008, 32'd3, 4'd4);
    poll(p);
    rd(12'h024, 4'd4, v); chk("R6 fact cause", v, 32'h1);
    chk("R8 irq high", {31'b0, irq_o}, 32'h1);
    rd(12'h020, 4'd4, v); chk("R6 status after done", v, 32'h80);
    wr(12'h064, 32'h1, 4'd4);
    #1 chk("R8 irq low", {31'b0, irq_o}, 32'h0);

    // R9 DMA pulse and priority over same-cycle clear
    @(negedge clk); dma_done_i = 1'b1;
    @(posedge clk); #1 dma_done_i = 1'b0;
    rd(12'h024, 4'd4, v); chk("R9 dma cause", v, 32'h100);
    chk("R8 irq from dma", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    bus_addr = 12'h064; bus_wdata = 32'h100; bus_size = 4'd4; bus_wr = 1'b1; dma_done_i = 1'b1;
    @(posedge clk); #1 begin bus_wr = 1'b0; dma_done_i = 1'b0; end
    rd(12'h024, 4'd4, v); chk("R9 set wins over clear", v, 32'h100);
    wr(12'h064, 32'h100, 4'd4);
    rd(12'h024, 4'd4, v); chk("R7 cleared", v, 32'h0);

    // R11 reset in the middle of activity
    wr(12'h060, 32'hF, 4'd4);
    wr(12'h004, 32'h0, 4'd4);
    wr(12'h008, 32'd10, 4'd4);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R11 irq drops at once", {31'b0, irq_o}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h004, 4'd4, v); chk("R11 scratch after", v, 32'h0);
    rd(12'h008, 4'd4, v); chk("R11 result after", v, 32'h0);
    rd(12'h020, 4'd4, v); chk("R11 status after", v, 32'h0);
    rd(12'h024, 4'd4, v); chk("R11 irq status after", v, 32'h0);

    finish_run();
  end
endmodule